// File: doc/BRIEF.md
# Embedded-Clock Word Serializer Channel

This block turns a stream of 10-bit parallel words into a single serial line. Every word becomes a 12-bit frame. A high start bit opens the frame and a low stop bit closes it, so each frame carries a guaranteed rising edge that a receiver can use to recover the word clock. The channel runs on a bit clock at twelve times the word rate. A shared timing source gives it a one-cycle word strobe once every twelve bit clocks, and the parallel word is sampled on that strobe.

A receiver that has lost lock asks for training by holding the sync request input high. Once the request has been seen on four consecutive word strobes, the channel stops sending payload. In its place it sends a training frame of six ones followed by six zeros, repeated until the request drops. Switching between data and training only happens at a frame boundary. Three enables gate the line: driver enable, master power-up and channel power-up. Only when all three are high does the block report the line as driven. Dropping either power-up also returns the channel to its post-reset state.

Top module: `ecw_serializer`

## Requirements
- R1: Every frame is 12 bit-clock cycles long. The first bit on the line after the loading strobe is the start bit, always 1, and the last (twelfth) bit is the stop bit, always 0.
- R2: Payload bits go out least-significant first: frame positions 1 to 10 carry data bit 0 to data bit 9.
- R3: A word sampled on word strobe k is sent in the frame that starts on strobe k+1, i.e. one word period of latency.
- R4: Once sync_req has been high on 4 consecutive word strobes, the frame that starts on the next strobe is a training frame and the payload is ignored.
- R5: A sync_req run shorter than 4 strobes has no effect. Any strobe that samples sync_req low restarts the qualification count from zero.
- R6: A training frame is six 1 bits followed by six 0 bits, and training frames repeat while sync_req stays high.
- R7: After sync_req is sampled low, data frames resume on the next frame boundary, carrying the word sampled on the previous strobe. No frame is ever cut short.
- R8: ser_drive is 1 only when drv_en, master_up and chan_up are all 1. While ser_drive is 0, ser_out is 0 (reported high-impedance).
- R9: While master_up or chan_up is 0, the channel is cleared at each clock: qualification count, held word and shift register. After power returns, the first frame carries an all-zero payload.
- R10: drv_en low only blanks the line. Framing, held word and sync qualification keep running, so the frame sequence after re-enable matches an uninterrupted one.
- R11: After reset, ser_out is 0 until the first frame is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twelve times the word rate |
| rst_n | input | 1 | Synchronous active-low reset |
| word_stb | input | 1 | One-cycle word strobe, one every 12 clocks |
| data_in | input | 10 | Parallel payload word, sampled on word_stb |
| sync_req | input | 1 | Training request, sampled on word_stb |
| drv_en | input | 1 | Line driver enable |
| master_up | input | 1 | Master power-up, active high |
| chan_up | input | 1 | Channel power-up, active high |
| ser_out | output | 1 | Serial line value, 0 when not driven |
| ser_drive | output | 1 | 1 when the line is actively driven |

## Verification
The hardest case to reach is the exact edge of sync qualification. A request has to sit high for precisely three strobes, be broken by a single low strobe, and then be re-raised, all while the one-word latency shifts which frame shows the result. The bench builds these runs strobe by strobe and predicts every frame from a model of the count and the held word. It also drops the driver enable in the middle of a training run, to show that qualification state survives a blanked line. Finally, a full sweep of all payload values confirms bit order and latency frame by frame.

// File: rtl/ecw_pkg.sv
// Package: shared types for the embedded-clock word serializer.
// Assumes nothing beyond the 1800-2017 language.
package ecw_pkg;
    // Frame content selected for the next frame boundary.
    typedef enum logic {
        FRM_DATA  = 1'b0,
        FRM_TRAIN = 1'b1
    } frame_kind_e;
endpackage

// File: rtl/ecw_sync_qual.sv
// Module: counts consecutive word strobes with the training request high.
// Saturates at QUAL_LEN and raises 'qualified' from then on. A strobe that
// samples the request low, or the clear input, restarts the count.
// Assumes stb is a one-cycle pulse.
module ecw_sync_qual #(
    parameter int QUAL_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic req,
    output logic qualified
);
    localparam int CNT_W = $clog2(QUAL_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_LEN);

    logic [CNT_W-1:0] run_cnt;

    // Track the run length of high requests seen on strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_cnt <= '0;
        end else if (stb) begin
            if (!req) begin
                run_cnt <= '0;
            end else if (run_cnt != CNT_MAX) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // Qualified once the full run has been observed.
    always_comb begin
        qualified = (run_cnt == CNT_MAX);
    end
endmodule

// File: rtl/ecw_frame_build.sv
// Module: assembles one serial frame from a payload word or the training
// pattern. Bit 0 is sent first. A data frame is {stop=0, word, start=1};
// a training frame is ones in its first half and zeros in its second half.
// Pure combinational logic.
module ecw_frame_build
    import ecw_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  frame_kind_e            kind,
    input  logic [WORD_W-1:0]      word,
    output logic [WORD_W+1:0]      frame
);
    localparam int FRAME_W = WORD_W + 2;
    localparam int HALF_W  = FRAME_W / 2;

    logic [FRAME_W-1:0] train_pat;
    logic [FRAME_W-1:0] data_pat;

    // Training pattern: first half ones, second half zeros.
    for (genvar i = 0; i < FRAME_W; i++) begin : g_train
        assign train_pat[i] = (i < HALF_W);
    end

    // Data pattern with framing clock bits around the payload.
    always_comb begin
        data_pat = {1'b0, word, 1'b1};
    end

    // Select the frame content.
    always_comb begin
        frame = (kind == FRM_TRAIN) ? train_pat : data_pat;
    end
endmodule

// File: rtl/ecw_frame_shift.sv
// Module: parallel-load, shift-right register that presents one frame bit
// per clock, LSB first. Loads on 'load', fills with zeros while shifting.
// Assumes loads arrive no more often than once per FRAME_W clocks.
module ecw_frame_shift #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               bit_out
);
    logic [FRAME_W-1:0] shreg;

    // Load a new frame or move the current one towards the line.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= frame_in;
        end else begin
            shreg <= {1'b0, shreg[FRAME_W-1:1]};
        end
    end

    // Current line bit.
    always_comb begin
        bit_out = shreg[0];
    end
endmodule

// File: rtl/ecw_line_gate.sv
// Module: decides whether the line is driven and blanks the bit when not.
// Pure combinational logic.
module ecw_line_gate (
    input  logic bit_in,
    input  logic drv_en,
    input  logic master_up,
    input  logic chan_up,
    output logic ser_out,
    output logic ser_drive
);
    // Line drive decision and blanking.
    always_comb begin
        ser_drive = drv_en && master_up && chan_up;
        ser_out   = ser_drive && bit_in;
    end
endmodule

// File: rtl/ecw_serializer.sv
// Module: one embedded-clock serializer channel.
// On each word strobe it captures the parallel word and loads the frame
// built from the word held since the previous strobe (or a training frame
// if the sync request is qualified), giving one word of latency. Either
// power-up input low clears the channel. drv_en only blanks the line.
// Assumes word_stb pulses once every WORD_W+2 clocks.
module ecw_serializer
    import ecw_pkg::*;
#(
    parameter int WORD_W   = 10,
    parameter int QUAL_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] data_in,
    input  logic              sync_req,
    input  logic              drv_en,
    input  logic              master_up,
    input  logic              chan_up,
    output logic              ser_out,
    output logic              ser_drive
);
    localparam int FRAME_W = WORD_W + 2;

    logic               pwr_clr;
    logic               sync_ok;
    logic [WORD_W-1:0]  held_word;
    frame_kind_e        next_kind;
    logic [FRAME_W-1:0] next_frame;
    logic               line_bit;

    // Channel is cleared while either power-up input is low.
    always_comb begin
        pwr_clr = !(master_up && chan_up);
    end

    // Capture the payload word on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_clr) begin
            held_word <= '0;
        end else if (word_stb) begin
            held_word <= data_in;
        end
    end

    ecw_sync_qual #(
        .QUAL_LEN (QUAL_LEN)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pwr_clr),
        .stb       (word_stb),
        .req       (sync_req),
        .qualified (sync_ok)
    );

    // Choose frame content from the qualification state before this strobe.
    always_comb begin
        next_kind = sync_ok ? FRM_TRAIN : FRM_DATA;
    end

    ecw_frame_build #(
        .WORD_W (WORD_W)
    ) u_build (
        .kind  (next_kind),
        .word  (held_word),
        .frame (next_frame)
    );

    ecw_frame_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pwr_clr),
        .load     (word_stb),
        .frame_in (next_frame),
        .bit_out  (line_bit)
    );

    ecw_line_gate u_gate (
        .bit_in    (line_bit),
        .drv_en    (drv_en),
        .master_up (master_up),
        .chan_up   (chan_up),
        .ser_out   (ser_out),
        .ser_drive (ser_drive)
    );
endmodule

// File: rtl/ecw_serializer_chk.sv
// Module: protocol checker bound to ecw_serializer. Tracks the bit position
// within the frame from the strobe and checks framing and line gating.
module ecw_serializer_chk #(
    parameter int WORD_W = 10
) (
    input logic clk,
    input logic rst_n,
    input logic word_stb,
    input logic master_up,
    input logic chan_up,
    input logic ser_out,
    input logic ser_drive
);
    localparam int FRAME_W = WORD_W + 2;
    localparam int POS_W   = $clog2(FRAME_W);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_W - 1);

    logic [POS_W-1:0] pos;
    logic             seen;

    // Bit position within the current frame, restarted by each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            seen <= 1'b0;
        end else if (word_stb) begin
            pos  <= '0;
            seen <= 1'b1;
        end else if (pos != POS_LAST) begin
            pos <= pos + 1'b1;
        end
    end

    // R1: start bit is 1 when a frame was loaded while powered.
    a_r1_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        seen && pos == '0 && ser_drive && $past(rst_n) && $past(master_up && chan_up)
        |-> ser_out);

    // R1: stop bit is 0.
    a_r1_stop_bit: assert property (@(posedge clk) disable iff (!rst_n)
        seen && pos == POS_LAST |-> !ser_out);

    // R1: strobes keep the frame period.
    a_r1_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb && seen |-> pos == POS_LAST);

    // R8: an undriven line is low.
    a_r8_blank_line: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_drive |-> !ser_out);

    // R9: a power-down clock leaves the line low.
    a_r9_pwrdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(master_up && chan_up) |-> !ser_out);

    // R11: the line is low right after reset.
    a_r11_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !ser_out);
endmodule

bind ecw_serializer ecw_serializer_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_stb  (word_stb),
    .master_up (master_up),
    .chan_up   (chan_up),
    .ser_out   (ser_out),
    .ser_drive (ser_drive)
);

// File: tb/ecw_serializer_bench.sv
// Bench: drives one word per 12 clocks and predicts every frame from a
// model of the qualification count and the held word.
module ecw_serializer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 10;
    localparam int FRAME_W    = WORD_W + 2;
    localparam int QUAL       = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_stb = 1'b0;
    logic [WORD_W-1:0] data_in = '0;
    logic              sync_req = 1'b0;
    logic              drv_en = 1'b1;
    logic              master_up = 1'b1;
    logic              chan_up = 1'b1;
    logic              ser_out;
    logic              ser_drive;

    int errors = 0;
    int checks = 0;

    int                 m_cnt = 0;
    logic [WORD_W-1:0]  m_hold = '0;
    logic               pend = 1'b0;
    logic [FRAME_W-1:0] pend_exp;
    logic [FRAME_W-1:0] got;
    logic               drv_bad;
    string              pend_tag;

    ecw_serializer #(.WORD_W(WORD_W), .QUAL_LEN(QUAL)) u_ecw_serializer (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .data_in(data_in),
        .sync_req(sync_req), .drv_en(drv_en), .master_up(master_up),
        .chan_up(chan_up), .ser_out(ser_out), .ser_drive(ser_drive)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_frame(input string tag, input logic [FRAME_W-1:0] act,
                               input logic [FRAME_W-1:0] exp, input logic dbad);
        checks++;
        if (act !== exp || dbad) begin
            errors++;
            $display("FAIL %s: frame got %b expected %b (drive mismatch=%0d)",
                     tag, act, exp, dbad);
        end
    endtask

    // One word period: finish the previous frame, strobe, collect bits 0..10.
    task automatic run_word(input logic [WORD_W-1:0] d, input logic s,
                            input logic de, input logic mu, input logic cu,
                            input string tag);
        logic [FRAME_W-1:0] exp;
        logic               edrv;
        @(negedge clk);
        if (pend) begin
            got[FRAME_W-1] = ser_out;
            check_frame(pend_tag, got, pend_exp, drv_bad);
        end
        word_stb = 1'b1; data_in = d; sync_req = s;
        drv_en = de; master_up = mu; chan_up = cu;
        edrv = de && mu && cu;
        if (!(mu && cu)) begin
            exp = '0; m_cnt = 0; m_hold = '0;
        end else begin
            exp = (m_cnt >= QUAL) ? {{(FRAME_W/2){1'b0}}, {(FRAME_W/2){1'b1}}}
                                  : {1'b0, m_hold, 1'b1};
            m_cnt = s ? ((m_cnt < QUAL) ? m_cnt + 1 : QUAL) : 0;
            m_hold = d;
        end
        if (!edrv) exp = '0;
        drv_bad = 1'b0;
        for (int j = 0; j < FRAME_W - 1; j++) begin
            @(negedge clk);
            word_stb = 1'b0;
            got[j] = ser_out;
            if (ser_drive !== edrv) drv_bad = 1'b1;
        end
        pend = 1'b1; pend_exp = exp; pend_tag = tag;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: line low out of reset
        checks++;
        if (ser_out !== 1'b0) begin
            errors++;
            $display("FAIL R11: ser_out got %b expected 0", ser_out);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (ser_out !== 1'b0 || ser_drive !== 1'b1) begin
            errors++;
            $display("FAIL R11: out/drive got %b%b expected 01", ser_out, ser_drive);
        end

        // R1 R2 R3: every payload value, sync low
        for (int i = 0; i < (1 << WORD_W); i++)
            run_word(WORD_W'(i), 1'b0, 1'b1, 1'b1, 1'b1, "R1 R2 R3 sweep");

        // R5: three high strobes, then low: no training
        for (int i = 0; i < 3; i++)
            run_word(10'h155 + WORD_W'(i), 1'b1, 1'b1, 1'b1, 1'b1, "R5 short run");
        run_word(10'h2AA, 1'b0, 1'b1, 1'b1, 1'b1, "R5 short run");
        // R5: 2 high, 1 low, 3 high: count restarts, still no training
        run_word(10'h001, 1'b1, 1'b1, 1'b1, 1'b1, "R5 restart");
        run_word(10'h002, 1'b1, 1'b1, 1'b1, 1'b1, "R5 restart");
        run_word(10'h004, 1'b0, 1'b1, 1'b1, 1'b1, "R5 restart");
        for (int i = 0; i < 3; i++)
            run_word(10'h100 >> i, 1'b1, 1'b1, 1'b1, 1'b1, "R5 restart");
        // R4 R6: fourth high strobe qualifies; training repeats
        for (int i = 0; i < 5; i++)
            run_word(10'h3C3, 1'b1, 1'b1, 1'b1, 1'b1, "R4 R6 training");
        // R10 R8: blank the line mid-training, qualification survives
        run_word(10'h0F0, 1'b1, 1'b0, 1'b1, 1'b1, "R10 R8 blanked");
        run_word(10'h0F1, 1'b1, 1'b0, 1'b1, 1'b1, "R10 R8 blanked");
        run_word(10'h0F2, 1'b1, 1'b1, 1'b1, 1'b1, "R10 R6 re-enabled");
        // R7: drop sync, data resumes on frame boundary
        run_word(10'h123, 1'b0, 1'b1, 1'b1, 1'b1, "R7 exit");
        run_word(10'h321, 1'b0, 1'b1, 1'b1, 1'b1, "R7 resume");
        run_word(10'h3FF, 1'b0, 1'b1, 1'b1, 1'b1, "R7 resume");
        // R9 R8: channel power-down clears held word
        run_word(10'h1AB, 1'b1, 1'b1, 1'b1, 1'b0, "R9 R8 chan down");
        run_word(10'h2CD, 1'b0, 1'b1, 1'b1, 1'b1, "R9 chan up");
        run_word(10'h3EF, 1'b0, 1'b1, 1'b1, 1'b1, "R9 chan up");
        // R9: master power-down mid-qualification clears count
        for (int i = 0; i < 3; i++)
            run_word(10'h055, 1'b1, 1'b1, 1'b1, 1'b1, "R9 pre-qual");
        run_word(10'h0AA, 1'b1, 1'b1, 1'b0, 1'b1, "R9 R8 master down");
        for (int i = 0; i < 3; i++)
            run_word(10'h111, 1'b1, 1'b1, 1'b1, 1'b1, "R9 count cleared");
        run_word(10'h222, 1'b1, 1'b1, 1'b1, 1'b1, "R9 R4 requalify");
        run_word(10'h333, 1'b0, 1'b1, 1'b1, 1'b1, "R6 R4 training");
        run_word(10'h000, 1'b0, 1'b1, 1'b1, 1'b1, "R7 flush");
        run_word(10'h000, 1'b0, 1'b1, 1'b1, 1'b1, "R7 flush");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule